// File: doc/BRIEF.md
# Byte-wide flash configuration loader

This block is the master side of a configuration path. It reads a configuration image of fixed length from a parallel NOR flash, one byte per address, and sends each byte to a serial configuration sink. It makes the configuration clock itself by dividing the system clock by two. Each fetched byte becomes exactly eight clock pulses, most significant bit first, before the next flash address is issued.

A load starts when the active-low program request is released. The address starts at a base value and steps by one per byte. When the last byte has been shifted out, the flash is released, the configuration clock stops and a one-cycle done pulse is given. Driving the program request low at any time aborts the load and, on release, restarts it from the base address. An active-low error input halts a running load until the next program request.

Top module: `flash_cfg_loader`

## Requirements
- R1: After a synchronous reset, busy and done are low, flash_ce_n and flash_oe_n are high, cfg_clk is low and flash_addr equals BASE_ADDR. No load starts until prog_n has been sampled low and then high.
- R2: prog_n low on a clock edge clears the loader at that edge, with busy low, both flash enables high and cfg_clk low. The first edge with prog_n high after it was low starts a load at BASE_ADDR, so a request during a load restarts it from the first byte.
- R3: Bits leave on cfg_dout most significant bit first. The sink takes each bit on the rising edge of cfg_clk. cfg_dout never changes while cfg_clk is high. cfg_clk stays low for one system clock and high for the next while shifting.
- R4: Every fetched byte produces exactly 8 rising edges of cfg_clk before the next address is issued. cfg_clk is never high while busy is low.
- R5: The first address of a load is BASE_ADDR, and each later address is the previous one plus one (a 27-bit address). The address is stable while flash_oe_n is low, and exactly one byte is taken per address.
- R6: flash_ce_n is low for the whole load. flash_oe_n goes low when an address is issued, and the byte on flash_dq is latched READ_LAT system clocks later, at which point flash_oe_n returns high. flash_oe_n is never low while flash_ce_n is high.
- R7: After IMAGE_BYTES bytes, busy falls, both enables go high and done is high for exactly one clock. busy stays high for IMAGE_BYTES*(READ_LAT+16) clocks. No further load starts without a new program request.
- R8: err_n low on an edge while busy halts the load: busy low, enables high, cfg_clk stops low and no done pulse follows. The loader stays halted until a program request. err_n low while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n | input | 1 | Active-low program request; release starts a load |
| err_n | input | 1 | Active-low error; halts a running load |
| flash_dq | input | DATA_W | Flash read data |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| busy | output | 1 | High while a load is in progress |
| done | output | 1 | One-cycle pulse when the image is complete |

## Verification
A wrong latency counter makes the loader latch the flash bus before the model presents valid data. The received byte is then wrong within the first byte of the load. A bit counter or phase fault shows as a byte with other than eight rising clock edges at the next address step, or as a shifted byte stream. A byte counter fault changes the number of received bytes and the busy duration, which the bench checks to the exact cycle at the done pulse. Errors in abort and halt handling show at the edge after the request, as busy or a flash enable left active, or as a done pulse that should not appear.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_HALT
  } ld_state_t;
endpackage

// File: rtl/flash_cfg_addr.sv
module flash_cfg_addr #(
  parameter int ADDR_W = 27,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_base,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || set_base) begin
      addr <= BASE_ADDR;
    end else if (inc) begin
      addr <= addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/flash_cfg_ser.sv
module flash_cfg_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              run,
  input  logic [DATA_W-1:0] din,
  output logic              cfg_clk,
  output logic              cfg_dout,
  output logic              byte_end
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [BIT_W-1:0]  bit_cnt;
  logic              clk_q;

  // clock toggles every system clock while running; data moves on the falling step
  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bit_cnt <= '0;
      clk_q   <= 1'b0;
    end else if (clear) begin
      bit_cnt <= '0;
      clk_q   <= 1'b0;
    end else if (load) begin
      sh      <= din;
      bit_cnt <= '0;
      clk_q   <= 1'b0;
    end else if (run) begin
      clk_q <= ~clk_q;
      if (clk_q && (bit_cnt != LAST_BIT)) begin
        sh      <= {sh[DATA_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + BIT_W'(1);
      end
    end
  end

  assign cfg_clk  = clk_q;
  assign cfg_dout = sh[DATA_W-1];
  assign byte_end = run & clk_q & (bit_cnt == LAST_BIT);
endmodule

// File: rtl/flash_cfg_seq.sv
module flash_cfg_seq
  import flash_cfg_pkg::*;
#(
  parameter int IMAGE_BYTES = 16,
  parameter int READ_LAT    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_n,
  input  logic err_n,
  input  logic byte_end,
  output logic ser_clear,
  output logic ser_load,
  output logic ser_run,
  output logic addr_base,
  output logic addr_inc,
  output logic busy,
  output logic done,
  output logic ce_n,
  output logic oe_n
);
  localparam int LAT_W = $clog2(READ_LAT + 1);
  localparam int CNT_W = $clog2(IMAGE_BYTES + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(READ_LAT - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IMAGE_BYTES - 1);

  ld_state_t        state;
  logic             prog_q;
  logic [LAT_W-1:0] lat_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic             start;
  logic             halt_now;
  logic             fetch_done;

  assign start      = (state == ST_IDLE) & prog_n & ~prog_q;
  assign halt_now   = busy & ~err_n;
  assign fetch_done = (state == ST_FETCH) & (lat_cnt == LAT_LAST);

  assign ser_clear = ~prog_n | halt_now;
  assign ser_load  = fetch_done;
  assign ser_run   = (state == ST_SHIFT);
  assign addr_base = ~prog_n | start;
  assign addr_inc  = prog_n & ~halt_now & byte_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      prog_q   <= 1'b1;
      lat_cnt  <= '0;
      byte_cnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
    end else begin
      prog_q <= prog_n;
      done   <= 1'b0;
      if (!prog_n) begin
        state    <= ST_IDLE;
        lat_cnt  <= '0;
        byte_cnt <= '0;
        busy     <= 1'b0;
        ce_n     <= 1'b1;
        oe_n     <= 1'b1;
      end else if (halt_now) begin
        state <= ST_HALT;
        busy  <= 1'b0;
        ce_n  <= 1'b1;
        oe_n  <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start) begin
              state    <= ST_FETCH;
              lat_cnt  <= '0;
              byte_cnt <= '0;
              busy     <= 1'b1;
              ce_n     <= 1'b0;
              oe_n     <= 1'b0;
            end
          end
          ST_FETCH: begin
            if (fetch_done) begin
              state   <= ST_SHIFT;
              lat_cnt <= '0;
              oe_n    <= 1'b1;
            end else begin
              lat_cnt <= lat_cnt + LAT_W'(1);
            end
          end
          ST_SHIFT: begin
            if (byte_end) begin
              if (byte_cnt == CNT_LAST) begin
                state <= ST_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
                ce_n  <= 1'b1;
                oe_n  <= 1'b1;
              end else begin
                state    <= ST_FETCH;
                byte_cnt <= byte_cnt + CNT_W'(1);
                oe_n     <= 1'b0;
              end
            end
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cfg_loader.sv
module flash_cfg_loader #(
  parameter int ADDR_W      = 27,
  parameter int DATA_W      = 8,
  parameter int IMAGE_BYTES = 16,
  parameter int READ_LAT    = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_n,
  input  logic              err_n,
  input  logic [DATA_W-1:0] flash_dq,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              cfg_clk,
  output logic              cfg_dout,
  output logic              busy,
  output logic              done
);
  logic ser_clear;
  logic ser_load;
  logic ser_run;
  logic addr_base;
  logic addr_inc;
  logic byte_end;

  flash_cfg_seq #(
    .IMAGE_BYTES(IMAGE_BYTES),
    .READ_LAT   (READ_LAT)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .prog_n   (prog_n),
    .err_n    (err_n),
    .byte_end (byte_end),
    .ser_clear(ser_clear),
    .ser_load (ser_load),
    .ser_run  (ser_run),
    .addr_base(addr_base),
    .addr_inc (addr_inc),
    .busy     (busy),
    .done     (done),
    .ce_n     (flash_ce_n),
    .oe_n     (flash_oe_n)
  );

  flash_cfg_addr #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) addr_i (
    .clk     (clk),
    .rst     (rst),
    .set_base(addr_base),
    .inc     (addr_inc),
    .addr    (flash_addr)
  );

  flash_cfg_ser #(
    .DATA_W(DATA_W)
  ) ser_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (ser_clear),
    .load    (ser_load),
    .run     (ser_run),
    .din     (flash_dq),
    .cfg_clk (cfg_clk),
    .cfg_dout(cfg_dout),
    .byte_end(byte_end)
  );
endmodule

// File: rtl/flash_cfg_loader_chk.sv
module flash_cfg_loader_chk #(
  parameter int ADDR_W = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_n,
  input logic              err_n,
  input logic              busy,
  input logic              done,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              cfg_clk,
  input logic              cfg_dout,
  input logic [ADDR_W-1:0] flash_addr
);
  a_r2_prog_clears: assert property (@(posedge clk) disable iff (rst)
    !prog_n |=> (!busy && !done && flash_ce_n && flash_oe_n && !cfg_clk));

  a_r3_dout_stable: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> $stable(cfg_dout));

  a_r4_clk_needs_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> busy);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!flash_oe_n && !$past(flash_oe_n)) |-> $stable(flash_addr));

  a_r6_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> !flash_ce_n);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_err_halts: assert property (@(posedge clk) disable iff (rst)
    (busy && !err_n && prog_n) |=> (!busy && !done && flash_ce_n && !cfg_clk));
endmodule

bind flash_cfg_loader flash_cfg_loader_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .prog_n    (prog_n),
  .err_n     (err_n),
  .busy      (busy),
  .done      (done),
  .flash_ce_n(flash_ce_n),
  .flash_oe_n(flash_oe_n),
  .cfg_clk   (cfg_clk),
  .cfg_dout  (cfg_dout),
  .flash_addr(flash_addr)
);

// File: tb/flash_cfg_loader_tb_top.sv
module flash_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 27;
  localparam int DATA_W = 8;
  localparam int NB     = 12;
  localparam int LAT    = 3;
  localparam logic [ADDR_W-1:0] BASE = 27'h12345FA;
  localparam int LOAD_CYC = NB * (LAT + 16);
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_n = 1'b1;
  logic err_n = 1'b1;
  logic [DATA_W-1:0] flash_dq = '0;
  logic [ADDR_W-1:0] flash_addr;
  logic flash_ce_n, flash_oe_n, cfg_clk, cfg_dout, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cfg_loader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMAGE_BYTES(NB),
    .READ_LAT(LAT), .BASE_ADDR(BASE)
  ) dut_i (
    .clk(clk), .rst(rst), .prog_n(prog_n), .err_n(err_n),
    .flash_dq(flash_dq), .flash_addr(flash_addr),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] key = 8'h00;

  function automatic logic [7:0] flash_byte(input logic [ADDR_W-1:0] a, input logic [7:0] k);
    return (a[7:0] * 8'd29 + a[15:8]) ^ a[23:16] ^ k;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model: valid data only READ_LAT clocks after the address settles
  int fl_age = 0;
  logic [ADDR_W-1:0] fl_last = '0;
  always @(negedge clk) begin
    if (flash_oe_n) fl_age = 0;
    else if (flash_addr != fl_last) fl_age = 1;
    else if (fl_age < 1000) fl_age++;
    fl_last = flash_addr;
    flash_dq = (!flash_oe_n && fl_age >= LAT) ? flash_byte(flash_addr, key)
                                              : ~flash_byte(flash_addr, key);
  end

  // sink and protocol monitor
  logic mon_clr = 1'b0;
  logic [7:0] rx_mem [0:63];
  int rx_n, bitn, rises, rises_total, pulse_err, addr_err, done_cnt, busy_cyc, idle_clk_err;
  logic [7:0] bitacc;
  logic fetch_seen, clk_prev, oe_prev;
  logic [ADDR_W-1:0] addr_prev, exp_addr;
  initial begin
    rx_n = 0; bitn = 0; rises = 0; rises_total = 0; pulse_err = 0; addr_err = 0;
    done_cnt = 0; busy_cyc = 0; idle_clk_err = 0; bitacc = 0; fetch_seen = 0;
    clk_prev = 0; oe_prev = 1; addr_prev = '0; exp_addr = BASE;
  end
  always @(negedge clk) begin
    if (mon_clr) begin
      rx_n = 0; bitn = 0; rises = 0; pulse_err = 0; addr_err = 0; done_cnt = 0;
      busy_cyc = 0; idle_clk_err = 0; fetch_seen = 0; exp_addr = BASE;
    end else begin
      if (cfg_clk && !clk_prev) begin
        rises++; rises_total++;
        bitacc = {bitacc[6:0], cfg_dout};
        bitn++;
        if (bitn == 8) begin
          if (rx_n < 64) rx_mem[rx_n] = bitacc;
          rx_n++; bitn = 0;
        end
      end
      if (!flash_oe_n && oe_prev) begin
        if (fetch_seen && rises != 8) pulse_err++;
        fetch_seen = 1; rises = 0;
        if (flash_addr != exp_addr) addr_err++;
        exp_addr = exp_addr + 1'b1;
      end
      if (!flash_oe_n && !oe_prev && flash_addr != addr_prev) addr_err++;
      if (!flash_oe_n && flash_ce_n) addr_err++;
      if (done) begin
        done_cnt++;
        if (rises != 8) pulse_err++;
      end
      if (busy) busy_cyc++;
      if (cfg_clk && !busy) idle_clk_err++;
    end
    clk_prev = cfg_clk; oe_prev = flash_oe_n; addr_prev = flash_addr;
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mon_clear();
    mon_clr = 1'b1;
    wait_cyc(2);
    mon_clr = 1'b0;
  endtask

  // program request: low, monitor cleared while held, then released
  task automatic program_pulse();
    @(negedge clk);
    prog_n = 1'b0;
    @(negedge clk);
    chk(!busy && flash_ce_n && flash_oe_n && !cfg_clk, "R2", "cleared while prog low",
        {busy, flash_ce_n, flash_oe_n, cfg_clk}, 4'b0110);
    mon_clear();
    prog_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < LOAD_CYC + 40; i++) begin
      @(negedge clk);
      if (done_cnt != 0) break;
    end
    wait_cyc(20);
  endtask

  task automatic check_load(input string tag);
    int bad = 0;
    for (int i = 0; i < NB; i++)
      if (i < rx_n && rx_mem[i] != flash_byte(BASE + ADDR_W'(i), key)) bad++;
    chk(rx_n == NB, "R7", {tag, " byte count"}, rx_n, NB);
    chk(bad == 0, "R3", {tag, " msb-first data after latency (R6)"}, bad, 0);
    chk(pulse_err == 0, "R4", {tag, " eight pulses per byte"}, pulse_err, 0);
    chk(idle_clk_err == 0, "R4", {tag, " no clock while idle"}, idle_clk_err, 0);
    chk(addr_err == 0, "R5", {tag, " address sequence"}, addr_err, 0);
    chk(flash_addr == BASE + ADDR_W'(NB), "R5", {tag, " final address"}, flash_addr, BASE + ADDR_W'(NB));
    chk(busy_cyc == LOAD_CYC, "R7", {tag, " busy duration"}, busy_cyc, LOAD_CYC);
    chk(done_cnt == 1, "R7", {tag, " single done pulse"}, done_cnt, 1);
    chk(!busy && flash_ce_n && flash_oe_n, "R6", {tag, " enables released"},
        {busy, flash_ce_n, flash_oe_n}, 3'b011);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    int k;
    int snap;
    unused_seed = $urandom(32'h5EED);
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && flash_ce_n && flash_oe_n && !cfg_clk, "R1", "reset outputs",
        {busy, done, flash_ce_n, flash_oe_n, cfg_clk}, 5'b00110);
    chk(flash_addr == BASE, "R1", "reset address", flash_addr, BASE);
    mon_clear();
    wait_cyc(20);
    chk(!busy && flash_ce_n && rises_total == 0, "R1", "no start without request",
        {busy, flash_ce_n}, 2'b01);

    // directed load then random-key loads
    key = 8'h00;
    program_pulse(); wait_done(); check_load("directed");
    for (int n = 0; n < 3; n++) begin
      key = 8'($urandom);
      program_pulse(); wait_done(); check_load("random");
    end

    // R7 no restart after completion
    mon_clear();
    wait_cyc(40);
    chk(!busy && busy_cyc == 0, "R7", "no reload without request", busy_cyc, 0);

    // R2 restart mid-load
    for (int n = 0; n < 2; n++) begin
      key = 8'($urandom);
      program_pulse();
      k = $urandom_range(5, LOAD_CYC - 5);
      wait_cyc(k);
      program_pulse(); wait_done(); check_load("restart R2");
    end

    // R8 error halts a load
    for (int n = 0; n < 2; n++) begin
      key = 8'($urandom);
      program_pulse();
      k = $urandom_range(3, LOAD_CYC - 5);
      wait_cyc(k);
      err_n = 1'b0;
      @(negedge clk);
      err_n = 1'b1;
      chk(!busy && flash_ce_n && flash_oe_n && !cfg_clk, "R8", "halted after error",
          {busy, flash_ce_n, flash_oe_n, cfg_clk}, 4'b0110);
      snap = rises_total;
      wait_cyc(LOAD_CYC);
      chk(done_cnt == 0 && !busy && rises_total == snap, "R8", "stays halted, no done",
          done_cnt, 0);
    end

    // R8 error while idle is ignored
    key = 8'h5A;
    program_pulse(); wait_done();
    mon_clear();
    err_n = 1'b0;
    wait_cyc(4);
    err_n = 1'b1;
    chk(!busy && flash_ce_n && done_cnt == 0, "R8", "idle error no effect", busy, 0);
    program_pulse(); wait_done(); check_load("after idle error R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule